// File: doc/BRIEF.md
# Inclusion-Tracking Second-Level Snoop Filter

This block sits beside the tag and state store of a private second-level cache and is the only agent that watches the shared bus for that processor. The first-level cache never sees the bus directly. It relies on the second-level cache holding every block that it holds. Each second-level line carries two extra bits. The in-first-level bit records that the upper cache also holds the block. The stale bit records that the upper cache, which is write-back, has taken the block to modified, so the second-level data is out of date. With these bits the filter forwards a bus transaction upward only when it has to. It also handles a second-level eviction whose victim the upper cache still holds.

Snooped requests use a valid/ack handshake. A requester keeps `snp_vld` high and the filter answers with a one-cycle `snp_ack` that carries the shared and dirty results. Local maintenance operations use the same kind of handshake: fills into the second level, and the upper cache reporting that it took, modified or dropped a block. Any request sent to the first level is held on `l1_req_*` until a one-cycle `l1_ack` comes back. While that request is outstanding the bus answer is withheld. The store is direct-mapped, with `2**SET_W` lines. Addresses are block addresses: the low `SET_W` bits pick the line and the rest form the tag.

Top module: `l2_snoop_filter`

## Requirements
- R1: After reset every line is invalid and no request is pending. A snoop to any block is then answered with shared=0 and dirty=0, and nothing is sent upward.
- R2: A snoop that hits a line needing no upward action is answered with shared=1 and nothing is sent upward. This holds when the in-first-level bit is clear, and also for a bus read of a block that is present but not stale.
- R3: A bus read-exclusive (`snp_cmd`=1) that hits a line with the in-first-level bit set and the stale bit clear sends an invalidate (`l1_req_type`=0) for that block address. After the acknowledgement the line is invalid, so a later snoop of that block misses.
- R4: A bus read (`snp_cmd`=0) that hits a stale line sends a flush (`l1_req_type`=1) for that block and answers shared=1, dirty=1. Afterwards the line is clean and not stale, so a second bus read is answered dirty=0 with no upward request.
- R5: A bus read-exclusive that hits a stale line sends a flush-and-invalidate (`l1_req_type`=2) and answers dirty=1.
- R6: While an upward request is pending, `snp_ack` and `loc_ack` stay low and the request's type and address stay stable, however long `l1_ack` takes.
- R7: A local "first level modified" operation (`loc_op`=2) marks the second-level line modified as well, so a later bus read reports dirty=1.
- R8: A local fill (`loc_op`=0) into a line that holds another block sends an upward request for the victim address first. The request is an invalidate if the victim is in the first level and not stale, or a flush-and-invalidate if it is stale. The new block becomes present and clean only after the acknowledgement.
- R9: A local "first level dropped" operation (`loc_op`=3) clears the in-first-level bit, so a later read-exclusive to that block sends nothing upward.
- R10: When a snoop and a local operation are both valid while the filter is idle, the snoop is served first.
- R11: A bus read of a line that is modified in the second level but not stale is answered dirty=1 without any upward request, and leaves the line clean. A local "first level filled" operation is `loc_op`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_vld | input | 1 | Snooped bus request valid; held until `snp_ack` |
| snp_cmd | input | 1 | 0 = bus read, 1 = bus read-exclusive |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_ack | output | 1 | One-cycle answer to the snoop |
| snp_shared | output | 1 | Block present in this hierarchy (valid with `snp_ack`) |
| snp_dirty | output | 1 | This hierarchy supplies modified data (valid with `snp_ack`) |
| loc_vld | input | 1 | Local maintenance operation valid; held until `loc_ack` |
| loc_op | input | 2 | 0 fill L2, 1 L1 filled, 2 L1 modified, 3 L1 dropped |
| loc_addr | input | ADDR_W | Block address of the local operation |
| loc_ack | output | 1 | One-cycle completion of the local operation |
| l1_req_vld | output | 1 | Request to the first level pending |
| l1_req_type | output | 2 | 0 invalidate, 1 flush, 2 flush-and-invalidate |
| l1_req_addr | output | ADDR_W | Block address of the upward request |
| l1_ack | input | 1 | One-cycle acknowledgement from the first level |

## Verification
A wrong in-first-level bit shows at the ports the next time its block is snooped for ownership or evicted. An upward request appears that should not, or one is missing. A wrong stale or modified bit shows in the next bus read of that block, as a wrong dirty flag or a wrong flush. The stimulus therefore follows each state change with the snoop that exposes it, two to four cycles later. A failure to hold the bus answer back shows as `snp_ack` rising while `l1_req_vld` is still high.

// File: rtl/sf_pkg.sv
package sf_pkg;

   typedef enum logic {
      SNP_RD  = 1'b0,
      SNP_RDX = 1'b1
   } sf_snp_e;

   typedef enum logic [1:0] {
      OP_L2_FILL = 2'd0,
      OP_L1_FILL = 2'd1,
      OP_L1_MOD  = 2'd2,
      OP_L1_DROP = 2'd3
   } sf_op_e;

   typedef enum logic [1:0] {
      UP_INV   = 2'd0,
      UP_FLUSH = 2'd1,
      UP_PURGE = 2'd2
   } sf_up_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SACK = 2'd2,
      ST_LACK = 2'd3
   } sf_state_e;

   typedef struct packed {
      logic valid;
      logic dirty;
      logic incl;
      logic stale;
   } sf_flags_t;

endpackage

// File: rtl/sf_store.sv
module sf_store
   import sf_pkg::*;
#(
   parameter int SET_W = 3,
   parameter int TAG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output sf_flags_t        rd_flags,
   input  logic             we,
   input  logic [SET_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  sf_flags_t        wr_flags
);
   localparam int SETS = 1 << SET_W;

   logic [TAG_W-1:0] tag_q [SETS];
   sf_flags_t        flg_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tag_q[s] <= '0;
            flg_q[s] <= '0;
         end
      end else if (we) begin
         tag_q[wr_idx] <= wr_tag;
         flg_q[wr_idx] <= wr_flags;
      end
   end

   assign rd_tag   = tag_q[rd_idx];
   assign rd_flags = flg_q[rd_idx];
endmodule

// File: rtl/sf_decide.sv
module sf_decide
   import sf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SET_W  = 3,
   parameter int TAG_W  = 13,
   parameter bit WB_L1  = 1'b1
) (
   input  logic              is_snp,
   input  sf_snp_e           snp_cmd,
   input  sf_op_e            op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  cur_tag,
   input  sf_flags_t         cur,
   output logic              need_up,
   output sf_up_e            up_type,
   output logic [ADDR_W-1:0] up_addr,
   output logic              we,
   output logic [TAG_W-1:0]  new_tag,
   output sf_flags_t         new_flags,
   output logic              res_shared,
   output logic              res_dirty
);
   logic [TAG_W-1:0] req_tag;
   logic [SET_W-1:0] idx;
   logic             hit;
   logic             stale_eff;

   assign req_tag = addr[ADDR_W-1:SET_W];
   assign idx     = addr[SET_W-1:0];
   assign hit     = cur.valid && (cur_tag == req_tag);

   // Only a write-back upper level can leave the second level stale.
   generate
      if (WB_L1) begin : g_wb
         assign stale_eff = cur.stale;
      end else begin : g_wt
         assign stale_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      need_up    = 1'b0;
      up_type    = UP_INV;
      up_addr    = addr;
      we         = 1'b0;
      new_tag    = req_tag;
      new_flags  = cur;
      res_shared = 1'b0;
      res_dirty  = 1'b0;
      if (is_snp) begin
         res_shared = hit;
         res_dirty  = hit && cur.dirty;
         if (hit) begin
            we = 1'b1;
            if (snp_cmd == SNP_RDX) begin
               new_flags = '0;
               need_up   = cur.incl;
               up_type   = stale_eff ? UP_PURGE : UP_INV;
            end else begin
               new_flags.dirty = 1'b0;
               new_flags.stale = 1'b0;
               need_up         = stale_eff;
               up_type         = UP_FLUSH;
            end
         end
      end else begin
         unique case (op)
            OP_L2_FILL: if (!hit) begin
               we        = 1'b1;
               new_flags = '{valid: 1'b1, dirty: 1'b0, incl: 1'b0, stale: 1'b0};
               need_up   = cur.valid && cur.incl;
               up_type   = stale_eff ? UP_PURGE : UP_INV;
               up_addr   = {cur_tag, idx};
            end
            OP_L1_FILL: if (hit) begin
               we             = 1'b1;
               new_flags.incl = 1'b1;
            end
            OP_L1_MOD: if (hit) begin
               we              = 1'b1;
               new_flags.incl  = 1'b1;
               new_flags.dirty = 1'b1;
               new_flags.stale = WB_L1;
            end
            OP_L1_DROP: if (hit) begin
               we              = 1'b1;
               new_flags.incl  = 1'b0;
               new_flags.stale = 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl
   import sf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SET_W  = 3,
   parameter int TAG_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_vld,
   input  logic              loc_vld,
   input  logic              l1_ack,
   input  logic [SET_W-1:0]  idx,
   input  logic              dec_need_up,
   input  sf_up_e            dec_up_type,
   input  logic [ADDR_W-1:0] dec_up_addr,
   input  logic              dec_we,
   input  logic [TAG_W-1:0]  dec_tag,
   input  sf_flags_t         dec_flags,
   input  logic              dec_shared,
   input  logic              dec_dirty,
   output logic              st_we,
   output logic [SET_W-1:0]  st_idx,
   output logic [TAG_W-1:0]  st_tag,
   output sf_flags_t         st_flags,
   output logic              snp_ack,
   output logic              snp_shared,
   output logic              snp_dirty,
   output logic              loc_ack,
   output logic              up_vld,
   output sf_up_e            up_type,
   output logic [ADDR_W-1:0] up_addr
);
   sf_state_e        state_q;
   logic             pend_snp_q;
   logic             pend_we_q;
   logic [SET_W-1:0] pend_idx_q;
   logic [TAG_W-1:0] pend_tag_q;
   sf_flags_t        pend_flags_q;
   logic             take;

   // A snoop outranks a local operation; the decision inputs follow snp_vld.
   assign take = (state_q == ST_IDLE) && (snp_vld || loc_vld);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         pend_snp_q   <= 1'b0;
         pend_we_q    <= 1'b0;
         pend_idx_q   <= '0;
         pend_tag_q   <= '0;
         pend_flags_q <= '0;
         snp_shared   <= 1'b0;
         snp_dirty    <= 1'b0;
         up_type      <= UP_INV;
         up_addr      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take) begin
               if (snp_vld) begin
                  snp_shared <= dec_shared;
                  snp_dirty  <= dec_dirty;
               end
               if (dec_need_up) begin
                  state_q      <= ST_WAIT;
                  up_type      <= dec_up_type;
                  up_addr      <= dec_up_addr;
                  pend_snp_q   <= snp_vld;
                  pend_we_q    <= dec_we;
                  pend_idx_q   <= idx;
                  pend_tag_q   <= dec_tag;
                  pend_flags_q <= dec_flags;
               end else begin
                  state_q <= snp_vld ? ST_SACK : ST_LACK;
               end
            end
            ST_WAIT: if (l1_ack) begin
               state_q <= pend_snp_q ? ST_SACK : ST_LACK;
            end
            ST_SACK: state_q <= ST_IDLE;
            ST_LACK: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      st_we    = 1'b0;
      st_idx   = idx;
      st_tag   = dec_tag;
      st_flags = dec_flags;
      if (take && !dec_need_up) begin
         st_we = dec_we;
      end else if ((state_q == ST_WAIT) && l1_ack) begin
         st_we    = pend_we_q;
         st_idx   = pend_idx_q;
         st_tag   = pend_tag_q;
         st_flags = pend_flags_q;
      end
   end

   assign snp_ack = (state_q == ST_SACK);
   assign loc_ack = (state_q == ST_LACK);
   assign up_vld  = (state_q == ST_WAIT);
endmodule

// File: rtl/l2_snoop_filter.sv
module l2_snoop_filter
   import sf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SET_W  = 3,
   parameter bit WB_L1  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_vld,
   input  logic              snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_ack,
   output logic              snp_shared,
   output logic              snp_dirty,
   input  logic              loc_vld,
   input  logic [1:0]        loc_op,
   input  logic [ADDR_W-1:0] loc_addr,
   output logic              loc_ack,
   output logic              l1_req_vld,
   output logic [1:0]        l1_req_type,
   output logic [ADDR_W-1:0] l1_req_addr,
   input  logic              l1_ack
);
   localparam int TAG_W = ADDR_W - SET_W;

   initial begin
      if (SET_W < 1 || SET_W > 10) $error("SET_W out of range");
      if (TAG_W < 1) $error("ADDR_W must exceed SET_W");
   end

   logic [ADDR_W-1:0] cur_addr;
   logic [SET_W-1:0]  idx;
   logic [TAG_W-1:0]  rd_tag;
   sf_flags_t         rd_flags;
   logic              dec_need_up, dec_we, dec_shared, dec_dirty;
   sf_up_e            dec_up_type, up_type;
   logic [ADDR_W-1:0] dec_up_addr;
   logic [TAG_W-1:0]  dec_tag, st_tag;
   sf_flags_t         dec_flags, st_flags;
   logic              st_we;
   logic [SET_W-1:0]  st_idx;

   assign cur_addr = snp_vld ? snp_addr : loc_addr;
   assign idx      = cur_addr[SET_W-1:0];

   sf_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (idx),
      .rd_tag   (rd_tag),
      .rd_flags (rd_flags),
      .we       (st_we),
      .wr_idx   (st_idx),
      .wr_tag   (st_tag),
      .wr_flags (st_flags)
   );

   sf_decide #(.ADDR_W(ADDR_W), .SET_W(SET_W), .TAG_W(TAG_W), .WB_L1(WB_L1)) u_dec (
      .is_snp     (snp_vld),
      .snp_cmd    (sf_snp_e'(snp_cmd)),
      .op         (sf_op_e'(loc_op)),
      .addr       (cur_addr),
      .cur_tag    (rd_tag),
      .cur        (rd_flags),
      .need_up    (dec_need_up),
      .up_type    (dec_up_type),
      .up_addr    (dec_up_addr),
      .we         (dec_we),
      .new_tag    (dec_tag),
      .new_flags  (dec_flags),
      .res_shared (dec_shared),
      .res_dirty  (dec_dirty)
   );

   sf_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .TAG_W(TAG_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .snp_vld     (snp_vld),
      .loc_vld     (loc_vld),
      .l1_ack      (l1_ack),
      .idx         (idx),
      .dec_need_up (dec_need_up),
      .dec_up_type (dec_up_type),
      .dec_up_addr (dec_up_addr),
      .dec_we      (dec_we),
      .dec_tag     (dec_tag),
      .dec_flags   (dec_flags),
      .dec_shared  (dec_shared),
      .dec_dirty   (dec_dirty),
      .st_we       (st_we),
      .st_idx      (st_idx),
      .st_tag      (st_tag),
      .st_flags    (st_flags),
      .snp_ack     (snp_ack),
      .snp_shared  (snp_shared),
      .snp_dirty   (snp_dirty),
      .loc_ack     (loc_ack),
      .up_vld      (l1_req_vld),
      .up_type     (up_type),
      .up_addr     (l1_req_addr)
   );

   assign l1_req_type = up_type;
endmodule

// File: rtl/sf_chk.sv
module sf_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snp_ack,
   input logic              snp_shared,
   input logic              snp_dirty,
   input logic              loc_ack,
   input logic              l1_req_vld,
   input logic [1:0]        l1_req_type,
   input logic [ADDR_W-1:0] l1_req_addr,
   input logic              l1_ack
);
   // R6
   hold_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req_vld |-> (!snp_ack && !loc_ack));

   // R6
   req_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_req_vld && !l1_ack) |=> (l1_req_vld && $stable(l1_req_addr) && $stable(l1_req_type)));

   // R10
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({snp_ack, loc_ack, l1_req_vld}));

   // R3
   req_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req_vld |-> (l1_req_type != 2'd3));

   // R4
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_ack |=> !snp_ack);

   // R1
   miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_ack && !snp_shared) |-> !snp_dirty);
endmodule

bind l2_snoop_filter sf_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .snp_ack     (snp_ack),
   .snp_shared  (snp_shared),
   .snp_dirty   (snp_dirty),
   .loc_ack     (loc_ack),
   .l1_req_vld  (l1_req_vld),
   .l1_req_type (l1_req_type),
   .l1_req_addr (l1_req_addr),
   .l1_ack      (l1_ack)
);

// File: tb/tb_l2_snoop_filter.sv
`timescale 1ns/1ps
module tb_l2_snoop_filter;
   localparam int AW = 16;
   localparam logic [15:0] A = 16'h0012;
   localparam logic [15:0] B = 16'h0022;
   localparam logic [15:0] C = 16'h0015;

   typedef struct packed {
      logic        snp;
      logic [1:0]  code;
      logic [15:0] addr;
      logic        up;
      logic [1:0]  typ;
      logic [15:0] uaddr;
      logic [7:0]  lat;
      logic        sh;
      logic        dt;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd1},  // R1 miss
      '{1'b0, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8 fill empty line
      '{1'b1, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd2},  // R2 hit, not in L1
      '{1'b0, 2'd1, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd2},  // R2 L1 takes A
      '{1'b1, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd2},  // R2 read, clean
      '{1'b0, 2'd2, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd7},  // R7 L1 modifies A
      '{1'b1, 2'd0, A, 1'b1, 2'd1, A,     8'd3, 1'b1, 1'b1, 4'd4},  // R4 flush
      '{1'b1, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd4},  // R4 now clean
      '{1'b1, 2'd1, A, 1'b1, 2'd0, A,     8'd1, 1'b1, 1'b0, 4'd3},  // R3 invalidate
      '{1'b1, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd3},  // R3 gone
      '{1'b0, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 2'd1, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 2'd2, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 2'd0, B, 1'b1, 2'd2, A,     8'd2, 1'b0, 1'b0, 4'd8},  // R8 stale victim
      '{1'b1, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8 victim gone
      '{1'b1, 2'd0, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd8},  // R8 new block clean
      '{1'b0, 2'd1, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd5},  // R5
      '{1'b0, 2'd2, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd5},  // R5
      '{1'b1, 2'd1, B, 1'b1, 2'd2, B,     8'd20, 1'b1, 1'b1, 4'd5}, // R5 and R6 long hold
      '{1'b0, 2'd0, C, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd9},  // R9
      '{1'b0, 2'd1, C, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd9},  // R9
      '{1'b0, 2'd3, C, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd9},  // R9 drop
      '{1'b1, 2'd1, C, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd9},  // R9 nothing upward
      '{1'b0, 2'd0, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 2'd1, A, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 2'd0, B, 1'b1, 2'd0, A,     8'd1, 1'b0, 1'b0, 4'd8},  // R8 clean victim
      '{1'b0, 2'd1, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd11}, // R11
      '{1'b0, 2'd2, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd11}, // R11
      '{1'b0, 2'd3, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b0, 1'b0, 4'd11}, // R11 written back
      '{1'b1, 2'd0, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b1, 4'd11}, // R11 dirty, no flush
      '{1'b1, 2'd0, B, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd11}  // R11 clean after
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snp_vld = 1'b0, snp_cmd = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_ack, snp_shared, snp_dirty;
   logic          loc_vld = 1'b0;
   logic [1:0]    loc_op = '0;
   logic [AW-1:0] loc_addr = '0;
   logic          loc_ack;
   logic          l1_req_vld;
   logic [1:0]    l1_req_type;
   logic [AW-1:0] l1_req_addr;
   logic          l1_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   l2_snoop_filter dut (
      .clk(clk), .rst_n(rst_n),
      .snp_vld(snp_vld), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_ack(snp_ack), .snp_shared(snp_shared), .snp_dirty(snp_dirty),
      .loc_vld(loc_vld), .loc_op(loc_op), .loc_addr(loc_addr), .loc_ack(loc_ack),
      .l1_req_vld(l1_req_vld), .l1_req_type(l1_req_type), .l1_req_addr(l1_req_addr),
      .l1_ack(l1_ack)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      bit          seen = 0, done = 0, early = 0;
      int          cnt = 0;
      logic [1:0]  gtyp = '0;
      logic [15:0] gaddr = '0;
      logic        gsh = 0, gdt = 0;
      string       rq;
      rq = $sformatf("R%0d", v.rq);
      @(negedge clk);
      if (v.snp) begin
         snp_vld = 1'b1; snp_cmd = v.code[0]; snp_addr = v.addr;
      end else begin
         loc_vld = 1'b1; loc_op = v.code; loc_addr = v.addr;
      end
      while (!done) begin
         @(negedge clk);
         l1_ack = 1'b0;
         if (v.snp ? snp_ack : loc_ack) begin
            gsh = snp_shared; gdt = snp_dirty; done = 1;
            if (seen && cnt < int'(v.lat)) early = 1;
         end else if (l1_req_vld) begin
            if (!seen) begin
               seen = 1; gtyp = l1_req_type; gaddr = l1_req_addr;
            end
            cnt++;
            if (cnt >= int'(v.lat)) l1_ack = 1'b1;
         end
      end
      snp_vld = 1'b0; loc_vld = 1'b0;
      check(seen == v.up, rq, "upward request present", 32'(seen), 32'(v.up));
      if (v.up) begin
         check(gtyp == v.typ, rq, "upward type", 32'(gtyp), 32'(v.typ));
         check(gaddr == v.uaddr, rq, "upward address", 32'(gaddr), 32'(v.uaddr));
         // R6: answer only after the acknowledgement
         check(!early, "R6", "answer before l1 ack", 32'(early), 32'd0);
      end
      if (v.snp)
         check({gsh, gdt} == {v.sh, v.dt}, rq, "shared,dirty", 32'({gsh, gdt}), 32'({v.sh, v.dt}));
   endtask

   initial begin : watchdog
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      bit first_snp;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!l1_req_vld && !snp_ack && !loc_ack, "R1", "idle after reset",
            32'({l1_req_vld, snp_ack, loc_ack}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!l1_req_vld && !snp_ack && !loc_ack, "R1", "idle after reset release",
            32'({l1_req_vld, snp_ack, loc_ack}), 32'd0);

      for (int i = 0; i < NV; i++) run_vec(TBL[i]);

      // R10: snoop and local fill offered together, set 5 is empty
      @(negedge clk);
      snp_vld = 1'b1; snp_cmd = 1'b0; snp_addr = C;
      loc_vld = 1'b1; loc_op = 2'd0; loc_addr = C;
      first_snp = 0;
      while (!(snp_ack || loc_ack)) @(negedge clk);
      first_snp = snp_ack;
      check(first_snp, "R10", "snoop served first", 32'(first_snp), 32'd1);
      check(snp_shared == 1'b0, "R10", "snoop saw line before fill", 32'(snp_shared), 32'd0);
      snp_vld = 1'b0;
      while (!loc_ack) @(negedge clk);
      loc_vld = 1'b0;
      run_vec('{1'b1, 2'd0, C, 1'b0, 2'd0, 16'h0, 8'd1, 1'b1, 1'b0, 4'd10});

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule